// File: doc/BRIEF.md
# ECC Error Control and Logging Register Bank

This block is the software-visible side of an ECC-protected memory controller. A small word-indexed register port reaches a set of control and log registers. The block sits between the memory write path and the ECC checker. On the write side it holds two corruption masks, one for the 32 data bits and one for the 7 check bits. The masks are XORed into the next memory write and then clear themselves, so a test routine can plant single-bit or double-bit faults at chosen bit positions and see how the checker reacts.

On the read side the ECC checker reports correctable and uncorrectable events. Each report comes with the failing byte address and the raw stored data and code. The block keeps a sticky status bit for each class, which software clears by writing ones. It gates the status bits with an enable register to form one interrupt line. It counts correctable events in a counter that saturates and can be written by software. It also logs address, data and code separately for each class. A byte or halfword store is carried out as read-modify-write. Its internal read can therefore report an error at a sub-word address, so logged addresses are always aligned down to the word.

Top module: `ecc_reg_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While `mem_wr` is high, `mem_wdata_out` equals `mem_wdata_in` XOR the data mask and `mem_wcode_out` equals `mem_wcode_in` XOR the code mask. Code-mask bit n flips stored bit 32+n, which is code bit n.
- R3: One clock edge with `mem_wr` high clears both masks. A register write to a mask in that same cycle loads the written value, and that value stays in place.
- R4: `ce_evt` sets status bit 0 and `ue_evt` sets status bit 1 (index 0x0). The bits can be read from the next cycle and stay set until cleared.
- R5: A write to index 0x0 clears each status bit whose written bit is 1 and leaves the others alone. When a clear and a set of the same bit fall in the same cycle, the clear wins.
- R6: The enable register at index 0x1 holds bits [1:0] exactly as written, zero included, and reads zero in bits [31:2]. `irq` is high exactly when some status bit and its enable bit are both 1.
- R7: The counter at index 0x2 is CNT_W bits wide and reads zero-extended. A write loads wdata[CNT_W-1:0]. Each cycle with `ce_evt` high adds one. A software write in the same cycle takes precedence over the increment.
- R8: The counter holds at 2^CNT_W-1 and does not wrap.
- R9: The data mask sits at index 0x3 and the code mask at index 0x4 (bits [6:0], upper bits read zero). Both can be read back.
- R10: On every `ce_evt`, index 0x5 captures `err_addr` with bits [1:0] forced to zero, index 0x6 captures `err_data` and index 0x7 captures `err_code`. Register writes to these indices have no effect.
- R11: On every `ue_evt`, indices 0x8, 0x9 and 0xA capture the word-aligned address, the data and the code in the same way, independently of the correctable log. Indices 0xB to 0xF read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ce_evt | input | 1 | Correctable error reported by the checker |
| ue_evt | input | 1 | Uncorrectable error reported by the checker |
| err_addr | input | ADDR_W | Byte address of the failing access |
| err_data | input | 32 | Raw stored data of the failing word |
| err_code | input | 7 | Raw stored check bits of the failing word |
| mem_wr | input | 1 | Memory write happening this cycle |
| mem_wdata_in | input | 32 | Data about to be stored |
| mem_wcode_in | input | 7 | Check bits about to be stored |
| mem_wdata_out | output | 32 | Data after fault injection |
| mem_wcode_out | output | 7 | Check bits after fault injection |
| irq | output | 1 | Interrupt: enabled status bits ORed |

## Verification
On every cycle the assertions check the following. Masks are consumed by a write. Status bits follow the set and clear rule, with clear taking priority. The counter steps by one or holds at its maximum. A masked-off status never raises `irq`. Every log capture is word-aligned and follows its event. Some things only the bench's scenarios can show: the register index map, the read-back widths, and that a counter write takes precedence over an increment in the same cycle. They also show that writes to the log indices change nothing, and that the two log classes stay apart while random traffic mixes events, masks and clears.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 7;
  localparam int IDX_W  = 4;

  localparam logic [IDX_W-1:0] IX_STATUS  = 4'h0;
  localparam logic [IDX_W-1:0] IX_IRQ_EN  = 4'h1;
  localparam logic [IDX_W-1:0] IX_CE_CNT  = 4'h2;
  localparam logic [IDX_W-1:0] IX_INJ_D   = 4'h3;
  localparam logic [IDX_W-1:0] IX_INJ_C   = 4'h4;
  localparam logic [IDX_W-1:0] IX_CE_ADDR = 4'h5;
  localparam logic [IDX_W-1:0] IX_CE_DATA = 4'h6;
  localparam logic [IDX_W-1:0] IX_CE_CODE = 4'h7;
  localparam logic [IDX_W-1:0] IX_UE_ADDR = 4'h8;
  localparam logic [IDX_W-1:0] IX_UE_DATA = 4'h9;
  localparam logic [IDX_W-1:0] IX_UE_CODE = 4'hA;

  typedef struct packed {
    logic ue;
    logic ce;
  } err_bits_t;

  // Force the byte offset within a 32-bit word to zero.
  function automatic logic [63:0] align_word(input logic [63:0] a);
    return a & ~64'd3;
  endfunction

  // Status next state: sticky set, write-one-to-clear, clear dominant.
  function automatic err_bits_t status_next(input err_bits_t cur, input err_bits_t set,
                                            input err_bits_t clr);
    return (cur | set) & ~clr;
  endfunction
endpackage

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit
  import ecc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_data,
  input  logic              ld_code,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [DATA_W-1:0] data_out,
  output logic [CODE_W-1:0] code_out,
  output logic [DATA_W-1:0] mask_d,
  output logic [CODE_W-1:0] mask_c
);
  logic consume;
  assign consume = mem_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_d <= '0;
      mask_c <= '0;
    end else begin
      if (ld_data)      mask_d <= wdata;
      else if (consume) mask_d <= '0;
      if (ld_code)      mask_c <= wdata[CODE_W-1:0];
      else if (consume) mask_c <= '0;
    end
  end

  assign data_out = data_in ^ mask_d;
  assign code_out = code_in ^ mask_c;

  assert_mask_d_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !ld_data) |=> (mask_d == '0));
  assert_mask_c_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !ld_code) |=> (mask_c == '0));
  assert_mask_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume && !ld_data) |=> $stable(mask_d));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_regs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [CODE_W-1:0] cap_code
);
  logic [63:0]       addr_wide;
  logic [ADDR_W-1:0] addr_aligned;
  assign addr_wide    = align_word(64'(addr));
  assign addr_aligned = addr_wide[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_code <= '0;
    end else if (evt) begin
      cap_addr <= addr_aligned;
      cap_data <= data;
      cap_code <= code;
    end
  end

  // Applies to both log classes (R10 for correctable, R11 for uncorrectable).
  assert_cap_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_addr[1:0] == 2'b00);
  assert_cap_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cap_data == $past(data)) && (cap_code == $past(code)) &&
            (cap_addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2])));
  assert_cap_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap_addr) && $stable(cap_data) && $stable(cap_code));
endmodule

// File: rtl/ecc_status_ctrl.sv
module ecc_status_ctrl
  import ecc_regs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_evt,
  input  logic             ue_evt,
  input  logic             st_clr_we,
  input  logic [1:0]       st_clr_mask,
  input  logic             en_we,
  input  logic [1:0]       en_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [1:0]       status,
  output logic [1:0]       irq_en,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  err_bits_t set_bits, clr_bits, st_q, st_d;
  logic      cnt_at_max, cnt_step;

  assign set_bits   = '{ue: ue_evt, ce: ce_evt};
  assign clr_bits   = st_clr_we ? err_bits_t'(st_clr_mask) : '0;
  assign st_d       = status_next(st_q, set_bits, clr_bits);
  assign cnt_at_max = (cnt == CNT_MAX);
  assign cnt_step   = ce_evt && !cnt_at_max;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      irq_en <= '0;
      cnt    <= '0;
    end else begin
      st_q <= st_d;
      if (en_we) irq_en <= en_wdata;
      if (cnt_we)        cnt <= cnt_wdata;
      else if (cnt_step) cnt <= cnt + 1'b1;
    end
  end

  assign status = st_q;
  assign irq    = |(status & irq_en);

  assert_ce_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !(st_clr_we && st_clr_mask[0])) |=> status[0]);
  assert_ue_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !(st_clr_we && st_clr_mask[1])) |=> status[1]);
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_we && st_clr_mask[0]) |=> !status[0]);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(st_clr_we && st_clr_mask[1])) |=> status[1]);
  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);
  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && ce_evt && !cnt_at_max) |=> (cnt == $past(cnt) + 1'b1));
  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !ce_evt) |=> $stable(cnt));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && cnt_at_max) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/ecc_reg_bank.sv
module ecc_reg_bank
  import ecc_regs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [31:0]       err_data,
  input  logic [6:0]        err_code,
  input  logic              mem_wr,
  input  logic [31:0]       mem_wdata_in,
  input  logic [6:0]        mem_wcode_in,
  output logic [31:0]       mem_wdata_out,
  output logic [6:0]        mem_wcode_out,
  output logic              irq
);
  localparam int N_IDX = 1 << IDX_W;

  logic [N_IDX-1:0] wr_hit;
  genvar gi;
  generate
    for (gi = 0; gi < N_IDX; gi++) begin : g_dec
      assign wr_hit[gi] = reg_we && (reg_addr == IDX_W'(gi));
    end
  endgenerate

  logic [1:0]        status, irq_en;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] mask_d;
  logic [CODE_W-1:0] mask_c;
  logic [ADDR_W-1:0] ce_addr, ue_addr;
  logic [DATA_W-1:0] ce_data, ue_data;
  logic [CODE_W-1:0] ce_code, ue_code;

  ecc_status_ctrl #(.CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .st_clr_we(wr_hit[IX_STATUS]), .st_clr_mask(reg_wdata[1:0]),
    .en_we(wr_hit[IX_IRQ_EN]), .en_wdata(reg_wdata[1:0]),
    .cnt_we(wr_hit[IX_CE_CNT]), .cnt_wdata(reg_wdata[CNT_W-1:0]),
    .status(status), .irq_en(irq_en), .cnt(cnt), .irq(irq)
  );

  ecc_inject_unit u_inject (
    .clk(clk), .rst_n(rst_n),
    .ld_data(wr_hit[IX_INJ_D]), .ld_code(wr_hit[IX_INJ_C]), .wdata(reg_wdata),
    .mem_wr(mem_wr), .data_in(mem_wdata_in), .code_in(mem_wcode_in),
    .data_out(mem_wdata_out), .code_out(mem_wcode_out),
    .mask_d(mask_d), .mask_c(mask_c)
  );

  ecc_err_capture #(.ADDR_W(ADDR_W)) u_ce_log (
    .clk(clk), .rst_n(rst_n), .evt(ce_evt), .addr(err_addr), .data(err_data),
    .code(err_code), .cap_addr(ce_addr), .cap_data(ce_data), .cap_code(ce_code)
  );

  ecc_err_capture #(.ADDR_W(ADDR_W)) u_ue_log (
    .clk(clk), .rst_n(rst_n), .evt(ue_evt), .addr(err_addr), .data(err_data),
    .code(err_code), .cap_addr(ue_addr), .cap_data(ue_data), .cap_code(ue_code)
  );

  always_comb begin
    unique case (reg_addr)
      IX_STATUS:  reg_rdata = 32'(status);
      IX_IRQ_EN:  reg_rdata = 32'(irq_en);
      IX_CE_CNT:  reg_rdata = 32'(cnt);
      IX_INJ_D:   reg_rdata = mask_d;
      IX_INJ_C:   reg_rdata = 32'(mask_c);
      IX_CE_ADDR: reg_rdata = 32'(ce_addr);
      IX_CE_DATA: reg_rdata = ce_data;
      IX_CE_CODE: reg_rdata = 32'(ce_code);
      IX_UE_ADDR: reg_rdata = 32'(ue_addr);
      IX_UE_DATA: reg_rdata = ue_data;
      IX_UE_CODE: reg_rdata = 32'(ue_code);
      default:    reg_rdata = '0;
    endcase
  end

  assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 2'b00));
  assert_log_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[IX_CE_DATA] && !ce_evt) |=> $stable(ce_data));
endmodule

// File: tb/ecc_reg_bank_test.sv
module ecc_reg_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;
  localparam logic [31:0] CMAX = (32'd1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic ce_evt = 0, ue_evt = 0;
  logic [ADDR_W-1:0] err_addr = 0; logic [31:0] err_data = 0; logic [6:0] err_code = 0;
  logic mem_wr = 0; logic [31:0] mem_wdata_in = 0; logic [6:0] mem_wcode_in = 0;
  logic [31:0] mem_wdata_out; logic [6:0] mem_wcode_out; logic irq;

  int checks = 0, errors = 0;

  // Reference state kept by the bench.
  logic [1:0] m_st = 0, m_en = 0;
  logic [31:0] m_cnt = 0, m_md = 0, m_mc = 0;
  logic [31:0] m_ca = 0, m_cd = 0, m_cc = 0, m_ua = 0, m_ud = 0, m_uc = 0;

  ecc_reg_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .err_addr(err_addr), .err_data(err_data), .err_code(err_code),
    .mem_wr(mem_wr), .mem_wdata_in(mem_wdata_in), .mem_wcode_in(mem_wcode_in),
    .mem_wdata_out(mem_wdata_out), .mem_wcode_out(mem_wcode_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return 32'(m_st);   4'h1: return 32'(m_en);
      4'h2: return m_cnt;       4'h3: return m_md;
      4'h4: return m_mc;        4'h5: return m_ca;
      4'h6: return m_cd;        4'h7: return m_cc;
      4'h8: return m_ua;        4'h9: return m_ud;
      4'hA: return m_uc;        default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'h0: return "R5"; 4'h1: return "R6"; 4'h2: return "R7";
      4'h3, 4'h4: return "R9";
      4'h5, 4'h6, 4'h7: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_update();
    logic [1:0] clr;
    clr = (reg_we && reg_addr == 4'h0) ? reg_wdata[1:0] : 2'b00;
    m_st = (m_st | {ue_evt, ce_evt}) & ~clr;
    if (reg_we && reg_addr == 4'h1) m_en = reg_wdata[1:0];
    if (reg_we && reg_addr == 4'h2) m_cnt = reg_wdata & CMAX;
    else if (ce_evt && m_cnt != CMAX) m_cnt = m_cnt + 1;
    if (reg_we && reg_addr == 4'h3) m_md = reg_wdata; else if (mem_wr) m_md = 0;
    if (reg_we && reg_addr == 4'h4) m_mc = reg_wdata & 32'h7F; else if (mem_wr) m_mc = 0;
    if (ce_evt) begin
      m_ca = 32'(err_addr) & ~32'd3; m_cd = err_data; m_cc = 32'(err_code);
    end
    if (ue_evt) begin
      m_ua = 32'(err_addr) & ~32'd3; m_ud = err_data; m_uc = 32'(err_code);
    end
  endtask

  // Drive one cycle of inputs, compare combinational outputs, then advance the model.
  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd,
                      input logic ce, input logic ue, input logic [ADDR_W-1:0] ea,
                      input logic [31:0] ed, input logic [6:0] ec,
                      input logic mw, input logic [31:0] md, input logic [6:0] mc);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd;
    ce_evt = ce; ue_evt = ue; err_addr = ea; err_data = ed; err_code = ec;
    mem_wr = mw; mem_wdata_in = md; mem_wcode_in = mc;
    #1;
    check(reg_rdata == model_read(a), req_of(a), reg_rdata, model_read(a), "register read");
    if (mw) begin
      check(mem_wdata_out == (md ^ m_md), "R2", mem_wdata_out, md ^ m_md, "data out");
      check(mem_wcode_out == (mc ^ m_mc[6:0]), "R2", 32'(mem_wcode_out),
            32'(mc ^ m_mc[6:0]), "code out");
    end
    check(irq == |(m_st & m_en), "R6", 32'(irq), 32'(|(m_st & m_en)), "irq");
    model_update();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(input logic [3:0] a);
    step(0, a, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); reg_addr = 4'(i); #1;
      check(reg_rdata == 0, "R1", reg_rdata, 0, "reset value");
    end
    check(irq == 0, "R1", 32'(irq), 0, "reset irq");

    // R2/R9: masks load and corrupt the next write; code bit 6 is stored bit 38
    wr(4'h3, 32'h8000_0001);
    wr(4'h4, 32'hFFFF_FFC1);
    rd(4'h4);
    step(0, 4'h3, 0, 0, 0, 0, 0, 0, 1, 32'h1234_5678, 7'h15);
    // R3: masks consumed
    rd(4'h3); rd(4'h4);
    check(model_read(4'h3) == 0, "R3", model_read(4'h3), 0, "model mask cleared");
    // R3: load in same cycle as a write keeps the new value
    step(1, 4'h3, 32'h0000_0100, 0, 0, 0, 0, 0, 1, 32'hAAAA_5555, 7'h00);
    rd(4'h3);
    step(0, 4'h3, 0, 0, 0, 0, 0, 0, 1, 32'h0, 7'h7F);
    rd(4'h3);

    // R4/R10: correctable event, unaligned address from a sub-word store
    step(0, 4'h0, 0, 1, 0, 16'h1237, 32'hDEAD_BEEF, 7'h2A, 0, 0, 0);
    rd(4'h0); rd(4'h5); rd(4'h6); rd(4'h7); rd(4'h2);
    // R6: enable gates irq; zero reads back
    wr(4'h1, 32'hFFFF_FFFD); rd(4'h1);
    wr(4'h1, 32'h0000_0000); rd(4'h1);
    wr(4'h1, 32'h0000_0003); rd(4'h0);
    // R5: clear wins over simultaneous set; other bit untouched
    step(1, 4'h0, 32'h1, 1, 1, 16'h0042, 32'h0BAD_F00D, 7'h11, 0, 0, 0);
    rd(4'h0); rd(4'h8); rd(4'h9); rd(4'hA); rd(4'h5);
    wr(4'h0, 32'h3); rd(4'h0);
    // R10: write to a log index has no effect
    wr(4'h6, 32'h1111_1111); rd(4'h6);
    // R7: software write beats same-cycle increment
    step(1, 4'h2, 32'h5, 1, 0, 16'h0100, 32'h1, 7'h1, 0, 0, 0);
    rd(4'h2);
    // R8: saturation, with write masked to CNT_W bits
    wr(4'h2, 32'hFFFF_FFFF); rd(4'h2);
    step(0, 4'h2, 0, 1, 0, 16'h0200, 32'h2, 7'h2, 0, 0, 0);
    step(0, 4'h2, 0, 1, 0, 16'h0204, 32'h3, 7'h3, 0, 0, 0);
    rd(4'h2);
    check(model_read(4'h2) == CMAX, "R8", model_read(4'h2), CMAX, "model saturated");
    wr(4'h2, CMAX - 1);
    step(0, 4'h2, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    rd(4'h2);
    // R11: unused indices
    rd(4'hB); rd(4'hF);

    // Constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic we;
      logic [3:0] a;
      we = ($urandom % 4) == 0;
      a  = 4'($urandom % 16);
      step(we, a, ($urandom % 3 == 0) ? 32'($urandom % 4) : $urandom,
           ($urandom % 5) == 0, ($urandom % 7) == 0,
           ADDR_W'($urandom), $urandom, 7'($urandom),
           ($urandom % 3) == 0, $urandom, 7'($urandom));
    end
    rd(4'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule